// File: doc/BRIEF.md
# I2C Slave Register-File Front End

This block is the serial front end of a small peripheral that keeps its state in a byte-wide register file of 256 locations. A bus master on a two-wire I2C bus selects the device by a 7-bit address whose lowest bit comes from a strap pin, so two such devices can sit on one bus. The block runs entirely on a fast system clock: both bus lines are brought in through two-flop synchronisers and their edges are found by comparing successive samples. The block never clocks anything from SCL.

In a write transfer the first byte after the address is the word pointer. Every later byte is written to the location the pointer names, and the pointer then steps on by one. To read, the master writes the pointer, sends a repeated START and the address with the read bit set, and then clocks out bytes. Bytes come from the pointer, which again steps after each byte and wraps from 8'hFF to 8'h00. The register file itself sits outside the block, behind a simple synchronous port. A write strobe commits one byte. A read strobe returns data one clock later.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset the block drives no SDA low (sda_oe = 0) and issues neither a write strobe nor a read strobe.
- R2: The block answers only the device address {6'b101000, addr_pin} (bit 0 of the address byte is R/W, 1 = read). Any other address gets no acknowledge, and the rest of that transfer is ignored until the next START.
- R3: In a write transfer the first byte after the address loads the word pointer. Each later byte causes exactly one single-cycle mem_we with mem_addr equal to the pointer and mem_wdata equal to the byte.
- R4: The word pointer advances by one after every data byte written or read, wraps from 8'hFF to 8'h00, and keeps its value across START and STOP.
- R5: In a read transfer the block returns bytes from the word pointer, most significant bit first. It changes SDA only while SCL is low.
- R6: The block pulls SDA low during the ninth clock after each byte it accepts: a matching address, the pointer byte and each written data byte.
- R7: When the master does not acknowledge a read byte, the block releases SDA and stays silent until the next START.
- R8: A START or STOP at any point abandons the byte in progress and writes nothing. A START restarts address matching, and a STOP returns the block to idle.
- R9: SDA is driven only as an open-drain low enable (sda_oe). The enable never rises while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, pull the data line low |
| addr_pin | input | 1 | Strap for the lowest device-address bit |
| mem_addr | output | AW | Register-file address |
| mem_we | output | 1 | Register-file write strobe, one cycle |
| mem_wdata | output | 8 | Register-file write data |
| mem_re | output | 1 | Register-file read strobe, one cycle |
| mem_rdata | input | 8 | Register-file read data, valid one cycle after mem_re |

## Verification
The bench tests the pointer wrap both when writing and when reading across 8'hFF. A design with a wider or saturating counter would write or return the wrong location there. It aborts a data byte part-way with a STOP and with a repeated START. A design that commits partially shifted bits would emit a stray write strobe, and the bench's per-clock write monitor catches it. It sends the wrong address for each state of the strap pin and then sends data anyway. A design that matched loosely would acknowledge or write. It ends reads with a NACK and checks that SDA is released, because a slave that kept driving would hold the bus for the STOP.

// File: rtl/i2c_rf_pkg.sv
// Package: shared types and constants of the I2C register-file slave.
// Assumes byte-wide transfers and 7-bit device addressing.
package i2c_rf_pkg;

    localparam int BYTE_W    = 8;
    localparam int DEV_ADR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WPTR,
        ST_WDATA,
        ST_RDATA
    } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: brings SCL and SDA into the system clock domain and reports
// SCL edges and START/STOP conditions as single-cycle pulses.
// Assumes the system clock oversamples SCL by a wide margin.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    // Synchroniser chains and one-cycle history, idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_in};
            sda_chain <= {sda_chain[STAGES-2:0], sda_in};
            scl_prev  <= scl_lvl;
            sda_prev  <= sda_lvl;
        end
    end

    assign scl_lvl = scl_chain[STAGES-1];
    assign sda_lvl = sda_chain[STAGES-1];

    // Edge and bus-condition decode from the current and previous samples.
    always_comb begin
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
// Module: byte engine of the slave. It shifts bits in on SCL rise and out on
// SCL fall, matches the device address, keeps the word pointer, and
// drives the register-file port.
// Assumes synchronous memory reads with one cycle of latency, and an SCL
// high and low phase several system clocks long.
module i2c_slave_fsm
    import i2c_rf_pkg::*;
#(
    parameter int          AW      = 8,
    parameter logic [5:0]  ADDR_HI = 6'b101000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_pin,
    output logic              sda_oe,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata
);

    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

    slv_state_t          state;
    logic [CNT_W-1:0]    bitcnt;
    logic [BYTE_W-1:0]   shreg;
    logic [AW-1:0]       ptr;
    logic                rw;
    logic                rd_pend;
    logic                dev_hit;

    // Device address compare against the strapped pin.
    assign dev_hit = (shreg[BYTE_W-1:1] == {ADDR_HI, addr_pin});

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr       <= '0;
            rw        <= 1'b0;
            rd_pend   <= 1'b0;
            sda_oe    <= 1'b0;
            mem_addr  <= '0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            mem_re    <= 1'b0;
        end else begin
            mem_we  <= 1'b0;
            mem_re  <= 1'b0;
            rd_pend <= mem_re;
            if (rd_pend) begin
                shreg <= mem_rdata;
            end
            if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WPTR, ST_WDATA: begin
                        if (scl_rise && bitcnt < CNT_FULL) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == CNT_FULL) begin
                            if (state == ST_ADDR) begin
                                if (dev_hit) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                    bitcnt <= CNT_ACK;
                                    if (shreg[0]) begin
                                        mem_re   <= 1'b1;
                                        mem_addr <= ptr;
                                    end
                                end else begin
                                    state  <= ST_IDLE;
                                    bitcnt <= '0;
                                end
                            end else if (state == ST_WPTR) begin
                                ptr    <= shreg[AW-1:0];
                                sda_oe <= 1'b1;
                                bitcnt <= CNT_ACK;
                            end else begin
                                mem_we    <= 1'b1;
                                mem_addr  <= ptr;
                                mem_wdata <= shreg;
                                ptr       <= ptr + 1'b1;
                                sda_oe    <= 1'b1;
                                bitcnt    <= CNT_ACK;
                            end
                        end else if (scl_fall && bitcnt == CNT_ACK) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR && rw) begin
                                state  <= ST_RDATA;
                                sda_oe <= ~shreg[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= (state == ST_ADDR) ? ST_WPTR : ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall && bitcnt < CNT_LAST) begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == CNT_LAST) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                            bitcnt <= CNT_FULL;
                        end else if (scl_rise && bitcnt == CNT_FULL) begin
                            if (!sda_lvl) begin
                                mem_re   <= 1'b1;
                                mem_addr <= ptr;
                                bitcnt   <= CNT_ACK;
                            end else begin
                                state  <= ST_IDLE;
                                bitcnt <= '0;
                            end
                        end else if (scl_fall && bitcnt == CNT_ACK) begin
                            sda_oe <= ~shreg[BYTE_W-1];
                            bitcnt <= '0;
                        end
                    end
                    default: begin
                        bitcnt <= '0;
                    end
                endcase
            end
        end
    end

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !$past(scl_lvl)); // R9
    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n) start_det |=> (state == ST_ADDR && !sda_oe)); // R8
    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> (state == ST_IDLE && !sda_oe && !mem_we)); // R8
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we); // R3
    AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R3
    AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> ptr == AW'(mem_addr + 1'b1)); // R4
    AST_NO_WE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_RDATA) |-> !mem_we); // R5

endmodule

// File: rtl/i2c_regfile_slave.sv
// Module: top of the I2C register-file slave. It joins the line synchroniser
// and the byte engine and exposes an open-drain SDA enable and a
// synchronous register-file port.
// Assumes the register file answers mem_re with data one clock later.
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_HI     = 6'b101000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              addr_pin,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slave_fsm #(.AW(AW), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_pin  (addr_pin),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: tb/test_i2c_regfile_slave.sv
// Bench: a behavioural bus master and register file, plus a reference model
// (queues of expected writes, model memory and pointer) compared each clock.
module test_i2c_regfile_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_pin = 1'b0;
    logic       sda_oe;
    logic [7:0] mem_addr;
    logic       mem_we;
    logic [7:0] mem_wdata;
    logic       mem_re;
    logic [7:0] mem_rdata;
    logic       sda_bus;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] bmem [256];
    int         ref_mem [256];
    int         ref_ptr = 0;
    int         exp_a [$];
    int         exp_d [$];

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_regfile_slave i_i2c_regfile_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_bus),
        .sda_oe    (sda_oe),
        .addr_pin  (addr_pin),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata)
    );

    // Bench register file with one cycle of read latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= 8'((i * 7 + 3) % 256);
            mem_rdata <= '0;
        end else begin
            if (mem_we) bmem[mem_addr] <= mem_wdata;
            if (mem_re) mem_rdata <= bmem[mem_addr];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison of write strobes against the model queue (R3, R8, R2).
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_a.size() == 0) begin
                chk(1'b0, "R8 unexpected write", int'(mem_addr), -1);
            end else begin
                int ea, ed;
                ea = exp_a.pop_front();
                ed = exp_d.pop_front();
                chk(int'(mem_addr) == ea && int'(mem_wdata) == ed, "R3 write addr/data",
                    {mem_addr, mem_wdata}, (ea << 8) | ed);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(5);
        scl_m = 1'b1; wait_clk(10);
        sda_m = 1'b0; wait_clk(10);
        scl_m = 1'b0; wait_clk(5);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(5);
        scl_m = 1'b1; wait_clk(10);
        sda_m = 1'b1; wait_clk(10);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b;    wait_clk(5);
        scl_m = 1'b1; wait_clk(5);
        s = sda_bus;  wait_clk(5);
        scl_m = 1'b0; wait_clk(5);
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(!mack, s);
    endtask

    // Model-side data write: queue the expected strobe and update the model.
    task automatic model_write(input logic [7:0] d);
        bit ack;
        exp_a.push_back(ref_ptr);
        exp_d.push_back(int'(d));
        ref_mem[ref_ptr] = int'(d);
        ref_ptr = (ref_ptr + 1) % 256;
        write_byte(d, ack);
        chk(ack, "R6 data ack", ack, 1);
    endtask

    task automatic model_read(input bit mack);
        logic [7:0] b;
        read_byte(mack, b);
        chk(int'(b) == ref_mem[ref_ptr], "R5 R4 read data", b, ref_mem[ref_ptr]);
        ref_ptr = (ref_ptr + 1) % 256;
    endtask

    task automatic set_ptr(input logic [7:0] dev, input logic [7:0] p);
        bit ack;
        write_byte(dev, ack);
        chk(ack, "R2 R6 address ack", ack, 1);
        write_byte(p, ack);
        chk(ack, "R3 pointer ack", ack, 1);
        ref_ptr = int'(p);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        bit ack;
        logic s;
        for (int i = 0; i < 256; i++) ref_mem[i] = (i * 7 + 3) % 256;
        wait_clk(6);
        chk(sda_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1 reset outputs",
            {sda_oe, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        wait_clk(10);
        chk(sda_oe == 1'b0, "R1 idle after reset", sda_oe, 0);

        // Write three bytes from 0x10 (R3, R4, R6).
        bus_start();
        set_ptr(8'hA0, 8'h10);
        model_write(8'h11);
        model_write(8'h22);
        model_write(8'h33);
        bus_stop();
        chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);

        // Pointer write, repeated START, read three bytes, NACK last (R5, R7).
        bus_start();
        set_ptr(8'hA0, 8'h10);
        bus_start();
        write_byte(8'hA1, ack);
        chk(ack, "R2 read address ack", ack, 1);
        model_read(1'b1);
        model_read(1'b1);
        model_read(1'b0);
        wait_clk(5);
        chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
        bus_stop();

        // Fresh read continues from the advanced pointer (R4).
        bus_start();
        write_byte(8'hA1, ack);
        chk(ack, "R2 read address ack", ack, 1);
        model_read(1'b0);
        bus_stop();

        // Pointer wrap on write and on read (R4).
        bus_start();
        set_ptr(8'hA0, 8'hFE);
        model_write(8'hC1);
        model_write(8'hC2);
        model_write(8'hC3);
        bus_stop();
        bus_start();
        set_ptr(8'hA0, 8'hFF);
        bus_start();
        write_byte(8'hA1, ack);
        model_read(1'b1);
        model_read(1'b0);
        bus_stop();

        // Wrong address with pin low: no ack, following bytes ignored (R2).
        bus_start();
        write_byte(8'hA2, ack);
        chk(!ack, "R2 mismatch no ack", ack, 0);
        write_byte(8'h55, ack);
        chk(!ack, "R2 ignored byte no ack", ack, 0);
        write_byte(8'h66, ack);
        bus_stop();
        bus_start();
        write_byte(8'hA1, ack);
        model_read(1'b0);
        bus_stop();

        // Strap pin high moves the address (R2).
        addr_pin = 1'b1;
        bus_start();
        write_byte(8'hA0, ack);
        chk(!ack, "R2 pin high old address no ack", ack, 0);
        bus_stop();
        bus_start();
        set_ptr(8'hA2, 8'h40);
        model_write(8'h7E);
        bus_stop();
        bus_start();
        set_ptr(8'hA2, 8'h40);
        bus_start();
        write_byte(8'hA3, ack);
        model_read(1'b0);
        bus_stop();

        // STOP in the middle of a data byte writes nothing (R8).
        bus_start();
        set_ptr(8'hA2, 8'h50);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        bus_stop();
        bus_start();
        write_byte(8'hA3, ack);
        model_read(1'b0);
        bus_stop();

        // Repeated START in the middle of a data byte (R8).
        bus_start();
        set_ptr(8'hA2, 8'h60);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
        bus_start();
        write_byte(8'hA3, ack);
        chk(ack, "R8 restart address ack", ack, 1);
        model_read(1'b0);
        bus_stop();

        wait_clk(10);
        chk(exp_a.size() == 0, "R3 all expected writes seen", exp_a.size(), 0);
        chk(sda_oe == 1'b0, "R7 bus released at end", sda_oe, 0);
        finish_run();
    end

endmodule